// File: doc/BRIEF.md
# Two-Channel DMA Request Controller with Port Freeze

This block sequences the transfer requests of two DMA channels onto one shared bus master port. Software programs each channel through a small indexed register port. Each channel has a control word with an enable bit and a priority, a start address and a byte length. While a channel is enabled and still has bytes left to request, the controller offers one request at a time to the master port. It hands out addresses in steps of one beat. For each channel it keeps a count of the requests that have been accepted but have not yet completed.

Completed beats shrink the channel's length. When the length reaches zero the channel switches itself off and raises a done flag. When software turns a channel off, new requests stop at once, but the channel reports active until its outstanding requests drain. An error pulse from the master port aborts both channels and freezes the port. The error is held in a raw error register until software writes the reset register. A software reset also switches both channels off. It then waits until all outstanding requests have drained before it unfreezes the port.

Top module: `dma2_ctrl`

## Requirements
- R1: After reset, every register reads 0, no request is offered and both done flags are low.
- R2: The start address (index 1 for channel 0, 4 for channel 1) and the length (index 2 and 5) read back the value that was written, as long as no transfer is running.
- R3: A request is offered only for an enabled channel. Its address is the channel's current address, which advances by the beat size (4 bytes) on every accepted request. A channel stops requesting once its outstanding requests cover its remaining length.
- R4: When both channels can request, the one with the larger priority field wins. The control word is written at index 0 or 3, with bit 0 as enable and bits 2:1 as priority.
- R5: When both channels can request and their priorities are equal, grants alternate between them. The first tie after reset goes to channel 0.
- R6: Each completed beat lowers the length by 4. The beat that brings the length to 0 clears the enable and sets the channel's done flag (status bit 4 for channel 0, bit 5 for channel 1, also on chan_done). Writing the control word with enable set clears the flag.
- R7: After software clears the enable, no new request is offered. The channel still reads active (status bit 0 or 1) until its outstanding count reaches zero.
- R8: An error pulse clears both enables and all outstanding counts and sets the frozen status (bit 2). The raw error register (index 8) captures bit 0 = frozen, bits 2:1 = error code and bits 4:3 = the channels that were active.
- R9: While the port is frozen, no request is offered, even if a channel is enabled again.
- R10: A write to index 7 clears both enables and blocks requests and enable writes. It holds status bit 3 until no request is outstanding, and then clears the frozen state and the raw error register.
- R11: A channel never has more than 2 accepted-but-incomplete requests. At that limit it offers no further request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 4 | Register write index |
| cfg_wdata | input | 32 | Register write data |
| cfg_ridx | input | 4 | Register read index |
| cfg_rdata | output | 32 | Register read data (combinational) |
| mreq_valid | output | 1 | A request is offered to the master port |
| mreq_grant | input | 1 | Master port accepts the offered request this cycle |
| mreq_chan | output | 1 | Channel of the offered request |
| mreq_addr | output | 32 | Address of the offered request |
| mdone | input | 1 | One beat completed |
| mdone_chan | input | 1 | Channel of the completed beat |
| merr | input | 1 | Port error pulse |
| merr_code | input | 2 | Error code qualifying merr |
| chan_done | output | 2 | Per-channel done flags |

## Verification
The assertions assume that the master port reports a completion only for a channel that has a request outstanding, and that an error is a single-cycle pulse. They also assume that software does not write a control word in the same cycle as the reset register. The stimulus keeps its own count of outstanding requests per channel and issues a completion only when that count is above zero. It raises the error for exactly one cycle and spaces every register write into a cycle of its own. The expected request order is derived from the priority and alternation rules, and each accepted request is compared against that order.

// File: rtl/dma2_pkg.sv
package dma2_pkg;
  localparam int CH_COUNT  = 2;
  localparam int IDX_W     = 4;
  localparam int CH_STRIDE = 3;
  localparam int OFS_CTL   = 0;
  localparam int OFS_BASE  = 1;
  localparam int OFS_LEN   = 2;

  typedef enum logic [IDX_W-1:0] {
    RI_C0_CTL  = 4'd0,
    RI_C0_BASE = 4'd1,
    RI_C0_LEN  = 4'd2,
    RI_C1_CTL  = 4'd3,
    RI_C1_BASE = 4'd4,
    RI_C1_LEN  = 4'd5,
    RI_STATUS  = 4'd6,
    RI_SWRST   = 4'd7,
    RI_PERR    = 4'd8
  } reg_idx_e;
endpackage

// File: rtl/dma2_chan.sv
module dma2_chan #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 16,
  parameter int PRIO_W  = 2,
  parameter int BEAT    = 4,
  parameter int MAX_OUT = 2,
  parameter int OCNT_W  = $clog2(MAX_OUT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctl,
  input  logic              wr_base,
  input  logic              wr_len,
  input  logic [DATA_W-1:0] wdata,
  input  logic              en_lock,
  input  logic              kill,
  input  logic              abort,
  input  logic              issue,
  input  logic              beat_done,
  output logic              en,
  output logic [PRIO_W-1:0] prio,
  output logic [ADDR_W-1:0] base,
  output logic [LEN_W-1:0]  len,
  output logic [OCNT_W-1:0] ocnt,
  output logic              can_req,
  output logic              active,
  output logic              done_flag
);
  // length left after one completed beat, saturating at zero
  function automatic logic [LEN_W-1:0] shrink(input logic [LEN_W-1:0] l);
    return (l > LEN_W'(BEAT)) ? l - LEN_W'(BEAT) : '0;
  endfunction

  // room for one more request: below the cap and bytes not yet covered
  function automatic logic room(input logic [LEN_W-1:0] l, input logic [OCNT_W-1:0] o);
    return (o < OCNT_W'(MAX_OUT)) && (l > LEN_W'(o) * LEN_W'(BEAT));
  endfunction

  logic last_beat;
  logic ctl_ok;

  assign last_beat = beat_done && (len <= LEN_W'(BEAT));
  assign ctl_ok    = wr_ctl && !en_lock;
  assign can_req   = en && room(len, ocnt);
  assign active    = en || (ocnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en        <= 1'b0;
      prio      <= '0;
      base      <= '0;
      len       <= '0;
      ocnt      <= '0;
      done_flag <= 1'b0;
    end else begin
      if (wr_base)
        base <= wdata[ADDR_W-1:0];
      else if (issue && !abort)
        base <= base + ADDR_W'(BEAT);

      if (wr_len)
        len <= wdata[LEN_W-1:0];
      else if (beat_done && !abort)
        len <= shrink(len);

      if (abort)
        ocnt <= '0;
      else
        ocnt <= ocnt + OCNT_W'(issue) - OCNT_W'(beat_done);

      if (abort || kill)
        en <= 1'b0;
      else if (last_beat)
        en <= 1'b0;
      else if (ctl_ok)
        en <= wdata[0];

      if (ctl_ok)
        prio <= wdata[PRIO_W:1];

      if (last_beat && !abort)
        done_flag <= 1'b1;
      else if (ctl_ok && wdata[0])
        done_flag <= 1'b0;
    end
  end

  // R6: the beat that empties the length ends the channel and flags it
  assert_len_zero_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && len <= LEN_W'(BEAT) && !abort) |=> (!en && done_flag));

  // R7: outstanding work keeps the channel active into the next cycle
  assert_drain_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ocnt != '0 && !beat_done && !abort) |=> active);
endmodule

// File: rtl/dma2_arb.sv
module dma2_arb #(
  parameter int PRIO_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        elig,
  input  logic [PRIO_W-1:0] prio_a,
  input  logic [PRIO_W-1:0] prio_b,
  input  logic              take,
  output logic              valid,
  output logic              win
);
  logic last;

  function automatic logic pick(input logic [1:0] e, input logic [PRIO_W-1:0] pa,
                                input logic [PRIO_W-1:0] pb, input logic lst);
    if (e == 2'b10) return 1'b1;
    if (e == 2'b01) return 1'b0;
    if (pa > pb) return 1'b0;
    if (pb > pa) return 1'b1;
    return ~lst;
  endfunction

  assign valid = |elig;
  assign win   = pick(elig, prio_a, prio_b, last);

  always_ff @(posedge clk) begin
    if (!rst_n)
      last <= 1'b1;
    else if (take)
      last <= win;
  end

  // R5: back-to-back tied grants go to different channels
  assert_tie_alternates_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(take && elig == 2'b11 && prio_a == prio_b) && take && elig == 2'b11 && prio_a == prio_b)
      |-> (win != $past(win)));
endmodule

// File: rtl/dma2_errctl.sv
module dma2_errctl #(
  parameter int CODE_W = 2,
  parameter int NCH    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              merr,
  input  logic [CODE_W-1:0] merr_code,
  input  logic              swr_wr,
  input  logic [NCH-1:0]    active,
  input  logic              drained,
  output logic              frozen,
  output logic              swr_pending,
  output logic [CODE_W-1:0] err_code,
  output logic [NCH-1:0]    err_served
);
  logic swr_finish;
  assign swr_finish = swr_pending && drained;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frozen      <= 1'b0;
      swr_pending <= 1'b0;
      err_code    <= '0;
      err_served  <= '0;
    end else if (swr_finish) begin
      frozen      <= 1'b0;
      swr_pending <= 1'b0;
      err_code    <= '0;
      err_served  <= '0;
    end else begin
      if (swr_wr)
        swr_pending <= 1'b1;
      if (merr && !frozen) begin
        frozen     <= 1'b1;
        err_code   <= merr_code;
        err_served <= active;
      end
    end
  end

  // R9: the freeze lasts until a reset sequence is under way
  assert_freeze_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !swr_pending) |=> frozen);

  // R10: the reset sequence does not finish while requests are outstanding
  assert_reset_waits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (swr_pending && !drained) |=> swr_pending);
endmodule

// File: rtl/dma2_ctrl.sv
module dma2_ctrl
  import dma2_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 16,
  parameter int PRIO_W  = 2,
  parameter int BEAT    = 4,
  parameter int MAX_OUT = 2,
  parameter int CODE_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [IDX_W-1:0]  cfg_ridx,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              mreq_valid,
  input  logic              mreq_grant,
  output logic              mreq_chan,
  output logic [ADDR_W-1:0] mreq_addr,
  input  logic              mdone,
  input  logic              mdone_chan,
  input  logic              merr,
  input  logic [CODE_W-1:0] merr_code,
  output logic [CH_COUNT-1:0] chan_done
);
  localparam int NCH    = CH_COUNT;
  localparam int OCNT_W = $clog2(MAX_OUT + 1);

  logic [NCH-1:0]    en, can_req, active, done_f, issue, beat_done;
  logic [NCH-1:0]    wr_ctl, wr_base, wr_len, elig;
  logic [PRIO_W-1:0] prio [NCH];
  logic [ADDR_W-1:0] base [NCH];
  logic [LEN_W-1:0]  len  [NCH];
  logic [OCNT_W-1:0] ocnt [NCH];

  logic              frozen, swr_pending, swr_wr, drained, take, win, arb_valid, gate;
  logic [CODE_W-1:0] err_code;
  logic [NCH-1:0]    err_served;

  assign swr_wr = cfg_we && (cfg_idx == RI_SWRST);
  assign gate   = frozen || swr_pending || swr_wr;
  assign elig   = can_req & {NCH{~gate}};
  assign take   = arb_valid && mreq_grant;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign wr_ctl[c]    = cfg_we && (cfg_idx == IDX_W'(c * CH_STRIDE + OFS_CTL));
    assign wr_base[c]   = cfg_we && (cfg_idx == IDX_W'(c * CH_STRIDE + OFS_BASE));
    assign wr_len[c]    = cfg_we && (cfg_idx == IDX_W'(c * CH_STRIDE + OFS_LEN));
    assign issue[c]     = take && (win == 1'(c));
    assign beat_done[c] = mdone && (mdone_chan == 1'(c)) && (ocnt[c] != '0);

    dma2_chan #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PRIO_W(PRIO_W),
      .BEAT(BEAT), .MAX_OUT(MAX_OUT), .OCNT_W(OCNT_W)
    ) u_chan (
      .clk(clk), .rst_n(rst_n),
      .wr_ctl(wr_ctl[c]), .wr_base(wr_base[c]), .wr_len(wr_len[c]), .wdata(cfg_wdata),
      .en_lock(swr_pending || swr_wr), .kill(swr_wr), .abort(merr),
      .issue(issue[c]), .beat_done(beat_done[c]),
      .en(en[c]), .prio(prio[c]), .base(base[c]), .len(len[c]), .ocnt(ocnt[c]),
      .can_req(can_req[c]), .active(active[c]), .done_flag(done_f[c])
    );

    // R11: an offered request never pushes a channel past its cap
    assert_outstanding_cap_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mreq_valid && mreq_chan == 1'(c)) |-> (ocnt[c] < OCNT_W'(MAX_OUT)));
  end

  always_comb begin
    drained = 1'b1;
    for (int c = 0; c < NCH; c++)
      if (ocnt[c] != '0) drained = 1'b0;
  end

  dma2_arb #(.PRIO_W(PRIO_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .elig(elig), .prio_a(prio[0]), .prio_b(prio[1]),
    .take(take), .valid(arb_valid), .win(win)
  );

  dma2_errctl #(.CODE_W(CODE_W), .NCH(NCH)) u_err (
    .clk(clk), .rst_n(rst_n), .merr(merr), .merr_code(merr_code), .swr_wr(swr_wr),
    .active(active), .drained(drained), .frozen(frozen), .swr_pending(swr_pending),
    .err_code(err_code), .err_served(err_served)
  );

  assign mreq_valid = arb_valid;
  assign mreq_chan  = win;
  assign mreq_addr  = base[win];
  assign chan_done  = done_f;

  always_comb begin
    cfg_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (cfg_ridx == IDX_W'(c * CH_STRIDE + OFS_CTL))  cfg_rdata = DATA_W'({prio[c], en[c]});
      if (cfg_ridx == IDX_W'(c * CH_STRIDE + OFS_BASE)) cfg_rdata = DATA_W'(base[c]);
      if (cfg_ridx == IDX_W'(c * CH_STRIDE + OFS_LEN))  cfg_rdata = DATA_W'(len[c]);
    end
    if (cfg_ridx == RI_STATUS) cfg_rdata = DATA_W'({done_f, swr_pending, frozen, active});
    if (cfg_ridx == RI_PERR)   cfg_rdata = DATA_W'({err_served, err_code, frozen});
  end

  // R3: the offered channel is enabled
  assert_req_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |-> en[mreq_chan]);

  // R4: the higher priority field wins a contest
  assert_prio_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && elig == 2'b11 && prio[0] > prio[1]) |-> (mreq_chan == 1'b0));

  // R8: an error pulse leaves both channels off and the port frozen
  assert_abort_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    merr |=> (en == '0 && frozen));

  // R9: nothing is offered while frozen
  assert_no_req_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> !mreq_valid);

  // R10: nothing is offered while the reset sequence drains
  assert_no_req_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    swr_pending |-> !mreq_valid);
endmodule

// File: tb/dma2_ctrl_test.sv
module dma2_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  cfg_ridx = '0;
  logic [31:0] cfg_rdata;
  logic        mreq_valid, mreq_chan;
  logic        mreq_grant = 1'b0;
  logic [31:0] mreq_addr;
  logic        mdone = 1'b0, mdone_chan = 1'b0;
  logic        merr = 1'b0;
  logic [1:0]  merr_code = '0;
  logic [1:0]  chan_done;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  typedef struct { logic ch; logic [31:0] addr; string tag; } req_t;
  req_t expq[$];

  always #2 clk = ~clk;

  dma2_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .cfg_ridx(cfg_ridx), .cfg_rdata(cfg_rdata), .mreq_valid(mreq_valid), .mreq_grant(mreq_grant),
    .mreq_chan(mreq_chan), .mreq_addr(mreq_addr), .mdone(mdone), .mdone_chan(mdone_chan),
    .merr(merr), .merr_code(merr_code), .chan_done(chan_done)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] i, input logic [31:0] d);
    tick();
    cfg_we = 1'b1; cfg_idx = i; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] i, input logic [31:0] exp);
    cfg_ridx = i;
    @(negedge clk);
    check(req, $sformatf("reg[%0d]", i), cfg_rdata, exp);
  endtask

  task automatic out_chk(input string req, input string what, input logic [31:0] exp);
    @(negedge clk);
    case (what)
      "valid": check(req, what, 32'(mreq_valid), exp);
      "chan":  check(req, what, 32'(mreq_chan), exp);
      "addr":  check(req, what, mreq_addr, exp);
      default: check(req, what, 32'(chan_done), exp);
    endcase
  endtask

  task automatic beat(input logic ch);
    tick();
    mdone = 1'b1; mdone_chan = ch;
    tick();
    mdone = 1'b0;
  endtask

  function automatic void push(input logic ch, input logic [31:0] a, input string tag);
    req_t e;
    e.ch = ch; e.addr = a; e.tag = tag;
    expq.push_back(e);
  endfunction

  // scoreboard monitor: every accepted request must match the next expected one
  always @(negedge clk) begin
    if (rst_n && mreq_valid && mreq_grant) begin
      if (expq.size() == 0) begin
        checks++; fails++;
        $display("FAIL R3 unexpected request: actual ch%0d 0x%0h expected none", mreq_chan, mreq_addr);
      end else begin
        req_t e;
        e = expq.pop_front();
        check(e.tag, "granted channel", 32'(mreq_chan), 32'(e.ch));
        check(e.tag, "granted address", mreq_addr, e.addr);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    // R1: reset state
    out_chk("R1", "valid", 0);
    out_chk("R1", "done", 0);
    rd_chk("R1", 4'd6, 32'h0);
    rd_chk("R1", 4'd8, 32'h0);
    rd_chk("R1", 4'd0, 32'h0);

    // R2 readback, R3/R11 ordering, R6 completion
    wr(4'd1, 32'h1000);
    wr(4'd2, 32'd12);
    rd_chk("R2", 4'd1, 32'h1000);
    rd_chk("R2", 4'd2, 32'd12);
    push(1'b0, 32'h1000, "R3");
    push(1'b0, 32'h1004, "R3");
    push(1'b0, 32'h1008, "R11");
    mreq_grant = 1'b1;
    wr(4'd0, 32'h1);
    tick(4);
    out_chk("R11", "valid", 0);
    rd_chk("R7", 4'd6, 32'h01);
    beat(1'b0); tick(3);
    beat(1'b0); tick(2);
    beat(1'b0); tick(2);
    rd_chk("R6", 4'd6, 32'h10);
    rd_chk("R6", 4'd2, 32'h0);
    out_chk("R6", "done", 32'h1);

    // R4 priority
    mreq_grant = 1'b0;
    wr(4'd1, 32'h2000); wr(4'd2, 32'd8);
    wr(4'd4, 32'h3000); wr(4'd5, 32'd8);
    wr(4'd0, 32'h3); wr(4'd3, 32'h7);
    out_chk("R4", "chan", 1);
    out_chk("R4", "addr", 32'h3000);
    push(1'b1, 32'h3000, "R4"); push(1'b1, 32'h3004, "R4");
    push(1'b0, 32'h2000, "R4"); push(1'b0, 32'h2004, "R4");
    tick(); mreq_grant = 1'b1;
    tick(6);
    beat(1'b1); beat(1'b1); beat(1'b0); beat(1'b0);
    tick(2);
    rd_chk("R6", 4'd6, 32'h30);

    // R5 round robin on equal priority (last grant was channel 0)
    mreq_grant = 1'b0;
    wr(4'd1, 32'h4000); wr(4'd2, 32'd8);
    wr(4'd4, 32'h5000); wr(4'd5, 32'd8);
    wr(4'd0, 32'h5); wr(4'd3, 32'h5);
    out_chk("R5", "chan", 1);
    push(1'b1, 32'h5000, "R5"); push(1'b0, 32'h4000, "R5");
    push(1'b1, 32'h5004, "R5"); push(1'b0, 32'h4004, "R5");
    tick(); mreq_grant = 1'b1;
    tick(6);
    beat(1'b1); beat(1'b0); beat(1'b1); beat(1'b0);
    tick(2);
    rd_chk("R5", 4'd6, 32'h30);

    // R7 graceful disable
    mreq_grant = 1'b0;
    wr(4'd1, 32'h6000); wr(4'd2, 32'd64); wr(4'd0, 32'h1);
    push(1'b0, 32'h6000, "R11"); push(1'b0, 32'h6004, "R11");
    tick(); mreq_grant = 1'b1;
    tick(5);
    out_chk("R11", "valid", 0);
    mreq_grant = 1'b0;
    wr(4'd0, 32'h0);
    rd_chk("R7", 4'd6, 32'h21);
    out_chk("R7", "valid", 0);
    tick(); mreq_grant = 1'b1;
    tick(4);
    beat(1'b0); tick();
    rd_chk("R7", 4'd6, 32'h21);
    beat(1'b0); tick();
    rd_chk("R7", 4'd6, 32'h20);
    rd_chk("R7", 4'd2, 32'd56);

    // R8 error abort, R9 freeze
    mreq_grant = 1'b0;
    wr(4'd1, 32'h7000); wr(4'd2, 32'd16);
    wr(4'd4, 32'h8000); wr(4'd5, 32'd16);
    wr(4'd0, 32'h1); wr(4'd3, 32'h1);
    push(1'b1, 32'h8000, "R5"); push(1'b0, 32'h7000, "R5");
    push(1'b1, 32'h8004, "R5"); push(1'b0, 32'h7004, "R5");
    tick(); mreq_grant = 1'b1;
    tick(6);
    rd_chk("R8", 4'd6, 32'h03);
    tick(); merr = 1'b1; merr_code = 2'd2;
    tick(); merr = 1'b0;
    rd_chk("R8", 4'd6, 32'h04);
    rd_chk("R8", 4'd8, 32'd29);
    out_chk("R8", "valid", 0);
    wr(4'd0, 32'h1);
    tick(4);
    out_chk("R9", "valid", 0);
    rd_chk("R9", 4'd6, 32'h05);

    // R10 software reset clears freeze, then a fresh transfer runs
    wr(4'd7, 32'h0);
    tick(3);
    rd_chk("R10", 4'd6, 32'h00);
    rd_chk("R10", 4'd8, 32'h00);
    push(1'b1, 32'h9000, "R10");
    wr(4'd4, 32'h9000); wr(4'd5, 32'd4); wr(4'd3, 32'h1);
    tick(3);
    beat(1'b1); tick(2);
    rd_chk("R10", 4'd6, 32'h20);

    // R10 software reset waits for outstanding requests
    mreq_grant = 1'b0;
    wr(4'd1, 32'hA000); wr(4'd2, 32'd64); wr(4'd0, 32'h1);
    push(1'b0, 32'hA000, "R3"); push(1'b0, 32'hA004, "R3");
    tick(); mreq_grant = 1'b1;
    tick(5);
    mreq_grant = 1'b0;
    wr(4'd7, 32'h0);
    rd_chk("R10", 4'd6, 32'h29);
    wr(4'd0, 32'h1);
    tick(); mreq_grant = 1'b1;
    beat(1'b0); tick();
    rd_chk("R10", 4'd6, 32'h29);
    beat(1'b0); tick(2);
    rd_chk("R10", 4'd6, 32'h20);
    rd_chk("R10", 4'd0, 32'h0);

    tick(2);
    check("R3", "pending expected requests", 32'(expq.size()), 32'd0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule